// File: doc/BRIEF.md
# Ternary Priority Rule Classifier

This block holds a small table of ternary rules and classifies a packet key against all of them at once. Each rule row carries a valid flag, a value, a per-bit care mask and an action code. A key is matched by every valid row whose cared-for bits equal the key. The block reports the lowest-numbered matching row and that row's action. When no row matches, it reports a miss and returns a programmable fallback action.

Software-side logic loads rules one row at a time through a write port that carries a row index. The same table serves packet classification and longest-prefix routing. For routing, a prefix is written by caring only about its leading bits, and rows are sorted longest-first so that the priority order picks the most specific route. Result outputs are registered and appear one cycle after the key is presented.

Top module: `tcls_top`

## Requirements
- R1: After reset every row is invalid, the fallback action is 0, and `res_valid` and `res_hit` are low. A lookup made straight after reset misses and returns action 0.
- R2: A mask bit of 1 requires the key bit to equal the stored value bit. A mask bit of 0 makes that key bit a wildcard. The key is packed as source address in [71:40], destination address in [39:8] and protocol in [7:0].
- R3: `res_valid` is high exactly in the cycle after a cycle with `lk_valid` high. The result in that cycle reflects every row compared against that key.
- R4: When several rows match, `res_row` is the lowest matching index and `res_action` is that row's action.
- R5: A row written with its valid flag at 0 never matches, whatever its value and mask hold.
- R6: On a miss, `res_hit` is 0, `res_row` is 0 and `res_action` equals the current fallback action.
- R7: A row write in the same cycle as a lookup does not affect that lookup. It does affect the next lookup.
- R8: A fallback write takes effect for lookups in later cycles only, not for a lookup in the same cycle.
- R9: While no lookup is presented, `res_hit`, `res_row` and `res_action` hold their last values.
- R10: A row whose mask is all zero matches every key. With rows sorted from longest to shortest prefix, the most specific prefix wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | 4 | Row index to write |
| wr_valid | input | 1 | Valid flag stored in the row |
| wr_value | input | 72 | Compare value stored in the row |
| wr_mask | input | 72 | Care mask stored in the row (1 = compare) |
| wr_action | input | 8 | Action code stored in the row |
| dflt_wr_en | input | 1 | Fallback action write strobe |
| dflt_wr_action | input | 8 | New fallback action |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | 72 | Lookup key |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_hit | output | 1 | At least one row matched |
| res_row | output | 4 | Winning row index |
| res_action | output | 8 | Winning action, or fallback on a miss |

## Verification
A lookup and a table update can land on the same clock edge. This applies both to a row write and to a fallback write. The bench provokes the collision by driving the write strobe and the lookup request in the same cycle, aimed at the row the key hits. It then judges that this result carries the old action, or the old fallback on a miss. A second lookup one cycle later must carry the new one.

// File: rtl/tcls_pkg.sv
package tcls_pkg;
   typedef enum logic [0:0] {
      PRIO_SCAN    = 1'b0,
      PRIO_ISOLATE = 1'b1
   } prio_style_e;
endpackage

// File: rtl/tcls_row.sv
module tcls_row #(
   parameter int KEY_W  = 72,
   parameter int ACT_W  = 8,
   parameter int IDX_W  = 4,
   parameter int ROW_ID = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_row,
   input  logic             wr_valid,
   input  logic [KEY_W-1:0] wr_value,
   input  logic [KEY_W-1:0] wr_mask,
   input  logic [ACT_W-1:0] wr_action,
   input  logic [KEY_W-1:0] key,
   output logic             match,
   output logic [ACT_W-1:0] action
);
   localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(ROW_ID);

   logic             valid_q;
   logic [KEY_W-1:0] value_q;
   logic [KEY_W-1:0] mask_q;
   logic [ACT_W-1:0] action_q;
   logic             sel;

   assign sel = wr_en && (wr_row == MY_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         value_q  <= '0;
         mask_q   <= '0;
         action_q <= '0;
      end else if (sel) begin
         valid_q  <= wr_valid;
         value_q  <= wr_value;
         mask_q   <= wr_mask;
         action_q <= wr_action;
      end
   end

   assign match  = valid_q && (((key ^ value_q) & mask_q) == '0);
   assign action = action_q;
endmodule

// File: rtl/tcls_prio.sv
module tcls_prio
   import tcls_pkg::*;
#(
   parameter int          ROWS  = 16,
   parameter prio_style_e STYLE = PRIO_SCAN,
   localparam int         IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic [ROWS-1:0]  req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   assign any = |req;

   generate
      if (STYLE == PRIO_SCAN) begin : g_scan
         always_comb begin
            idx = '0;
            for (int i = ROWS - 1; i >= 0; i--) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
      end else begin : g_isolate
         logic [ROWS-1:0] lowest;
         assign lowest = req & (~req + ROWS'(1));
         always_comb begin
            idx = '0;
            for (int i = 0; i < ROWS; i++) begin
               if (lowest[i]) idx = idx | IDX_W'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tcls_top.sv
module tcls_top
   import tcls_pkg::*;
#(
   parameter int          ROWS  = 16,
   parameter int          KEY_W = 72,
   parameter int          ACT_W = 8,
   parameter prio_style_e STYLE = PRIO_ISOLATE,
   localparam int         IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_row,
   input  logic             wr_valid,
   input  logic [KEY_W-1:0] wr_value,
   input  logic [KEY_W-1:0] wr_mask,
   input  logic [ACT_W-1:0] wr_action,
   input  logic             dflt_wr_en,
   input  logic [ACT_W-1:0] dflt_wr_action,
   input  logic             lk_valid,
   input  logic [KEY_W-1:0] lk_key,
   output logic             res_valid,
   output logic             res_hit,
   output logic [IDX_W-1:0] res_row,
   output logic [ACT_W-1:0] res_action
);
   initial begin
      if (ROWS < 2)  $error("tcls_top: ROWS must be at least 2");
      if (KEY_W < 1) $error("tcls_top: KEY_W must be positive");
      if (ACT_W < 1) $error("tcls_top: ACT_W must be positive");
   end

   logic [ROWS-1:0]  match_vec;
   logic [ACT_W-1:0] act_arr [ROWS];
   logic             any_hit;
   logic [IDX_W-1:0] win_idx;
   logic [ACT_W-1:0] dflt_q;
   logic [ACT_W-1:0] sel_action;

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         tcls_row #(
            .KEY_W (KEY_W),
            .ACT_W (ACT_W),
            .IDX_W (IDX_W),
            .ROW_ID(r)
         ) u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_row   (wr_row),
            .wr_valid (wr_valid),
            .wr_value (wr_value),
            .wr_mask  (wr_mask),
            .wr_action(wr_action),
            .key      (lk_key),
            .match    (match_vec[r]),
            .action   (act_arr[r])
         );
      end
   endgenerate

   tcls_prio #(
      .ROWS (ROWS),
      .STYLE(STYLE)
   ) u_prio (
      .req(match_vec),
      .any(any_hit),
      .idx(win_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dflt_q <= '0;
      else if (dflt_wr_en) dflt_q <= dflt_wr_action;
   end

   assign sel_action = any_hit ? act_arr[win_idx] : dflt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_hit    <= 1'b0;
         res_row    <= '0;
         res_action <= '0;
      end else begin
         res_valid <= lk_valid;
         if (lk_valid) begin
            res_hit    <= any_hit;
            res_row    <= any_hit ? win_idx : '0;
            res_action <= sel_action;
         end
      end
   end
endmodule

// File: rtl/tcls_checks.sv
module tcls_checks #(
   parameter int ROWS  = 16,
   parameter int IDX_W = 4,
   parameter int ACT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic [ROWS-1:0]  match_vec,
   input logic             res_valid,
   input logic             res_hit,
   input logic [IDX_W-1:0] res_row,
   input logic [ACT_W-1:0] res_action
);
   // R1: the result strobe is low in the first cycle out of reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> !res_valid);

   // R3: result strobe follows the request by one cycle
   a_r3_strobe_on: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);
   a_r3_strobe_off: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid);
   a_r3_hit_follows_rows: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (res_hit == $past(|match_vec)));

   // R4: a match in row 0 always wins
   a_r4_row0_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && match_vec[0]) |=> (res_hit && res_row == '0));

   // R6: a miss reports row 0
   a_r6_miss_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_row == '0));

   // R9: outputs hold with no request
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> ($stable(res_hit) && $stable(res_row) && $stable(res_action)));
endmodule

bind tcls_top tcls_checks #(
   .ROWS (ROWS),
   .IDX_W(IDX_W),
   .ACT_W(ACT_W)
) u_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_valid  (lk_valid),
   .match_vec (match_vec),
   .res_valid (res_valid),
   .res_hit   (res_hit),
   .res_row   (res_row),
   .res_action(res_action)
);

// File: tb/test_tcls_top.sv
module test_tcls_top;
   localparam int ROWS = 16;
   localparam int KW   = 72;
   localparam int AW   = 8;
   localparam int IW   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_row = '0;
   logic          wr_valid = 1'b0;
   logic [KW-1:0] wr_value = '0;
   logic [KW-1:0] wr_mask = '0;
   logic [AW-1:0] wr_action = '0;
   logic          dflt_wr_en = 1'b0;
   logic [AW-1:0] dflt_wr_action = '0;
   logic          lk_valid = 1'b0;
   logic [KW-1:0] lk_key = '0;
   logic          res_valid;
   logic          res_hit;
   logic [IW-1:0] res_row;
   logic [AW-1:0] res_action;

   always #2 clk = ~clk;

   tcls_top i_tcls_top (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_row(wr_row), .wr_valid(wr_valid),
      .wr_value(wr_value), .wr_mask(wr_mask), .wr_action(wr_action),
      .dflt_wr_en(dflt_wr_en), .dflt_wr_action(dflt_wr_action),
      .lk_valid(lk_valid), .lk_key(lk_key),
      .res_valid(res_valid), .res_hit(res_hit),
      .res_row(res_row), .res_action(res_action)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   bit            m_valid [ROWS];
   logic [KW-1:0] m_val   [ROWS];
   logic [KW-1:0] m_msk   [ROWS];
   logic [AW-1:0] m_act   [ROWS];
   logic [AW-1:0] m_dflt;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [12:0] expect_of(logic [KW-1:0] k);
      for (int r = 0; r < ROWS; r++) begin
         if (m_valid[r] && (((k ^ m_val[r]) & m_msk[r]) == '0))
            return {1'b1, IW'(r), m_act[r]};
      end
      return {1'b0, IW'(0), m_dflt};
   endfunction

   task automatic put_row(int r, bit v, logic [KW-1:0] val, logic [KW-1:0] msk,
                          logic [AW-1:0] a);
      @(negedge clk);
      wr_en = 1'b1; wr_row = IW'(r); wr_valid = v;
      wr_value = val; wr_mask = msk; wr_action = a;
      @(negedge clk);
      wr_en = 1'b0;
      m_valid[r] = v; m_val[r] = val; m_msk[r] = msk; m_act[r] = a;
   endtask

   task automatic look(logic [KW-1:0] k, string req);
      logic [12:0] e;
      e = expect_of(k);
      @(negedge clk);
      lk_valid = 1'b1; lk_key = k;
      @(negedge clk);
      lk_valid = 1'b0;
      chk(req, {19'd0, res_hit, res_row, res_action}, {19'd0, e});
   endtask

   function automatic logic [KW-1:0] mk(logic [31:0] s, logic [31:0] d, logic [7:0] p);
      return {s, d, p};
   endfunction

   initial begin
      for (int r = 0; r < ROWS; r++) begin
         m_valid[r] = 0; m_val[r] = '0; m_msk[r] = '0; m_act[r] = '0;
      end
      m_dflt = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", {31'd0, res_valid}, 32'd0);
      chk("R1", {31'd0, res_hit}, 32'd0);
      look(mk(32'h0a000001, 32'h0b000002, 8'd6), "R1");

      // R2: single-bit care sweep over every key bit
      for (int b = 0; b < KW; b++) begin
         put_row(0, 1'b1, KW'(1) << b, KW'(1) << b, 8'h40 + AW'(b));
         look(KW'(1) << b, "R2");
         look('0, "R2");
         look(~(KW'(1) << b), "R2");
      end
      put_row(0, 1'b0, '0, '0, 8'h00);

      // R10 / R4: all rows wildcard, invalidate from the top of priority down
      for (int r = 0; r < ROWS; r++) put_row(r, 1'b1, '0, '0, AW'(8'h80 + r));
      for (int r = 0; r < ROWS; r++) begin
         look(mk(32'hdeadbeef, 32'h12345678, AW'(r)), "R4");
         put_row(r, 1'b0, '1, '1, AW'(8'h80 + r));   // R5
      end
      // R5: fully invalid table with exact-match contents
      look('1, "R5");

      // R6: miss with a programmed fallback
      @(negedge clk); dflt_wr_en = 1'b1; dflt_wr_action = 8'h5a;
      @(negedge clk); dflt_wr_en = 1'b0; m_dflt = 8'h5a;
      look(mk(32'h1, 32'h2, 8'h3), "R6");

      // R10: longest prefix first on the destination field
      put_row(2, 1'b1, mk(0, 32'hc0a80100, 0), mk(0, 32'hffffff00, 0), 8'h24);
      put_row(5, 1'b1, mk(0, 32'hc0a80000, 0), mk(0, 32'hffff0000, 0), 8'h16);
      put_row(7, 1'b1, mk(0, 32'h0, 8'd17), mk(0, 32'h0, 8'hff), 8'h11);
      put_row(9, 1'b1, '0, '0, 8'h99);
      look(mk(32'h01020304, 32'hc0a80105, 8'd6), "R10");
      look(mk(32'h01020304, 32'hc0a8ee05, 8'd6), "R10");
      look(mk(32'h01020304, 32'h0a000001, 8'd17), "R10");
      look(mk(32'h01020304, 32'h0a000001, 8'd6), "R10");

      // R9: outputs hold with no request
      repeat (3) @(negedge clk);
      chk("R9", {31'd0, res_valid}, 32'd0);
      chk("R9", {19'd0, res_hit, res_row, res_action}, {19'd0, 1'b1, 4'd9, 8'h99});

      // R7: row write collides with a lookup that hits it
      @(negedge clk);
      wr_en = 1'b1; wr_row = 4'd2; wr_valid = 1'b1;
      wr_value = mk(0, 32'hc0a80100, 0); wr_mask = mk(0, 32'hffffff00, 0); wr_action = 8'h77;
      lk_valid = 1'b1; lk_key = mk(32'h5, 32'hc0a80109, 8'd1);
      @(negedge clk);
      wr_en = 1'b0; lk_valid = 1'b0;
      chk("R7", {31'd0, res_valid}, 32'd1);
      chk("R7", {19'd0, res_hit, res_row, res_action}, {19'd0, 1'b1, 4'd2, 8'h24});
      m_act[2] = 8'h77;
      look(mk(32'h5, 32'hc0a80109, 8'd1), "R7");

      // R7: invalidating the winning row in the lookup cycle
      @(negedge clk);
      wr_en = 1'b1; wr_row = 4'd2; wr_valid = 1'b0; wr_action = 8'h00;
      lk_valid = 1'b1; lk_key = mk(32'h5, 32'hc0a80109, 8'd1);
      @(negedge clk);
      wr_en = 1'b0; lk_valid = 1'b0;
      chk("R7", {19'd0, res_hit, res_row, res_action}, {19'd0, 1'b1, 4'd2, 8'h77});
      m_valid[2] = 0; m_act[2] = 8'h00;
      look(mk(32'h5, 32'hc0a80109, 8'd1), "R7");

      // R8: fallback write collides with a missing lookup
      put_row(9, 1'b0, '0, '0, 8'h00);
      @(negedge clk);
      dflt_wr_en = 1'b1; dflt_wr_action = 8'ha5;
      lk_valid = 1'b1; lk_key = mk(32'h9, 32'h9, 8'd9);
      @(negedge clk);
      dflt_wr_en = 1'b0; lk_valid = 1'b0;
      chk("R8", {19'd0, res_hit, res_row, res_action}, {19'd0, 1'b0, 4'd0, 8'h5a});
      m_dflt = 8'ha5;
      look(mk(32'h9, 32'h9, 8'd9), "R8");

      // R3: back-to-back lookups, each result one cycle later
      put_row(15, 1'b1, mk(32'haa, 0, 0), mk(32'hff, 0, 0), 8'hf5);
      @(negedge clk);
      lk_valid = 1'b1; lk_key = mk(32'haa, 0, 0);
      @(negedge clk);
      chk("R3", {19'd0, res_valid, res_row, res_action}, {19'd0, 1'b1, 4'd15, 8'hf5});
      lk_key = mk(32'hab, 0, 0);
      @(negedge clk);
      lk_valid = 1'b0;
      chk("R3", {19'd0, res_valid, res_hit, res_action}, {19'd0, 1'b1, 1'b0, 8'ha5});
      @(negedge clk);
      chk("R3", {31'd0, res_valid}, 32'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule